// File: doc/BRIEF.md
# SMBus Byte-Data Master

This block is an SMBus master for a host that needs only two transactions to one attached target: write one data byte to a register, and read one data byte back from a register. Software fills the target address, the command byte (the target's register index) and, for writes, the data byte. It then writes the control register, and the transfer starts on that write. The block drives SCL and SDA low through open-drain enables. A quarter-period tick from a parameterised divider times each bit.

When a transaction ends, the block sets a completion bit in a write-one-to-clear status register. A refused byte also sets a NACK bit. The same status register latches rising edges of an external client interrupt line, so one registered interrupt output, gated by a mask register, serves both the adapter and the attached device.

Register offsets on the 3-bit bus address:

| Offset | Register |
|---|---|
| 0 | control |
| 1 | target address (bits 6:0) |
| 2 | command byte |
| 3 | write data |
| 4 | read data |
| 5 | status |
| 6 | mask |

Reads are registered, so `bus_rdata` shows the register at `bus_addr` one clock later.

Top module: `smbus_bytemaster`

## Requirements
- R1: After reset, status reads 0x00 and mask reads 0x01 (only the client source masked). Control reads 0x00, `irq_out` is 0, and both `scl_oe` and `sda_oe` are 0. Whenever no transaction runs, both enables are 0.
- R2: Writing control (offset 0) with bit 0 set while idle starts a write. The bus carries START, address with R/W=0, command, data, then STOP. The target's register at the command index then holds the data byte.
- R3: Writing control with bit 1 set (bit 0 clear) while idle starts a read. The bus carries START, address with R/W=0, command, repeated START, address with R/W=1, and one byte answered by a master NACK, then STOP. The received byte appears at offset 4.
- R4: Control bit 7 reads 1 while a transaction runs. A control write during that time is ignored and starts no second transaction. The address, command and data bytes were captured at start, so later writes to those registers do not affect the running transaction.
- R5: A finished write sets status bit 1, and a finished read sets status bit 2.
- R6: If the target leaves any byte unacknowledged, the master ends with STOP and sets status bit 3 together with the completion bit for the direction. No data byte is delivered on a refused write.
- R7: Writing status with a 1 in a bit clears that bit. A 0 leaves the bit unchanged.
- R8: If a new event and a clear of the same status bit land on the same clock edge, the bit stays set. The client input passes a two-stage synchroniser, and an edge registers in status on the third clock edge after the input rises.
- R9: `irq_out` is the OR of the status bits whose mask bit is 0, registered one clock after status and mask. A mask bit of 1 suppresses that source but still lets its status bit set.
- R10: The read-data register changes only when a read completes with every byte acknowledged. Write transactions and refused reads leave it unchanged.
- R11: Status bit 0 latches rising edges of the client input only. A level held high after the bit is cleared does not set it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for `bus_addr` |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA line level |
| client_irq_in | input | 1 | Asynchronous interrupt from the attached device |
| irq_out | output | 1 | Registered interrupt, active high |

## Verification
The two functions that can meet in one cycle are the set path of a status bit and the software clear of that same bit. The bench raises the client line at a known negative edge. Counting the two synchroniser stages and the edge-detect flop, it places a status clear strobe on exactly the edge where the synchronised rise reaches status. The bit must read 1 afterwards, because the event wins. A second, plain clear must then take it to 0.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned ST_W   = 4;

  localparam logic [REG_AW-1:0] OFS_CTRL  = 3'd0;
  localparam logic [REG_AW-1:0] OFS_TADDR = 3'd1;
  localparam logic [REG_AW-1:0] OFS_CMD   = 3'd2;
  localparam logic [REG_AW-1:0] OFS_WDATA = 3'd3;
  localparam logic [REG_AW-1:0] OFS_RDATA = 3'd4;
  localparam logic [REG_AW-1:0] OFS_STAT  = 3'd5;
  localparam logic [REG_AW-1:0] OFS_MASK  = 3'd6;

  localparam int unsigned ST_CLIENT = 0;
  localparam int unsigned ST_WDONE  = 1;
  localparam int unsigned ST_RDONE  = 2;
  localparam int unsigned ST_NACK   = 3;

  localparam logic [ST_W-1:0] MASK_RST = 4'b0001;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_START,
    PH_BYTE,
    PH_STOP
  } smb_phase_e;
endpackage

// File: rtl/smb_sync.sv
module smb_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/smb_quarter_tick.sv
module smb_quarter_tick #(
  parameter int unsigned QDIV = 62
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = $clog2(QDIV + 1);
  localparam logic [CW-1:0] LAST = CW'(QDIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= (cnt == LAST);
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/smb_bit_engine.sv
module smb_bit_engine
  import smb_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic          start_rd,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] cmd,
  input  logic [DW-1:0] wdata,
  input  logic          sda_s,
  output logic          busy,
  output logic          scl_oe,
  output logic          sda_oe,
  output logic          done,
  output logic          done_rd,
  output logic          done_nack,
  output logic [DW-1:0] rx_byte
);
  localparam int unsigned BW = $clog2(DW + 1);
  localparam logic [BW-1:0] ACK_SLOT = BW'(DW);

  smb_phase_e     ph;
  logic [1:0]     q;
  logic [BW-1:0]  bitn;
  logic [1:0]     bidx;
  logic [DW-1:0]  shreg;
  logic           samp;
  logic           rd_q, nack_q, first_q;
  logic [AW-1:0]  a_q;
  logic [DW-1:0]  c_q, d_q;
  logic           scl_low, sda_low;

  assign busy = (ph != PH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph        <= PH_IDLE;
      q         <= '0;
      bitn      <= '0;
      bidx      <= '0;
      shreg     <= '0;
      samp      <= 1'b1;
      rd_q      <= 1'b0;
      nack_q    <= 1'b0;
      first_q   <= 1'b0;
      a_q       <= '0;
      c_q       <= '0;
      d_q       <= '0;
      done      <= 1'b0;
      done_rd   <= 1'b0;
      done_nack <= 1'b0;
      rx_byte   <= '0;
    end else begin
      done <= 1'b0;
      case (ph)
        PH_IDLE: begin
          if (start) begin
            ph      <= PH_START;
            q       <= '0;
            first_q <= 1'b1;
            bidx    <= '0;
            rd_q    <= start_rd;
            nack_q  <= 1'b0;
            a_q     <= tgt_addr;
            c_q     <= cmd;
            d_q     <= wdata;
          end
        end
        PH_START: begin
          if (tick) begin
            if (q == 2'd3) begin
              ph    <= PH_BYTE;
              q     <= '0;
              bitn  <= '0;
              shreg <= {a_q, (bidx != 2'd0)};
            end else begin
              q <= q + 2'd1;
            end
          end
        end
        PH_BYTE: begin
          if (tick) begin
            q <= q + 2'd1;
            if (q == 2'd2) samp <= sda_s;
            if (q == 2'd3) begin
              if (bitn != ACK_SLOT) begin
                shreg <= {shreg[DW-2:0], samp};
                bitn  <= bitn + 1'b1;
              end else begin
                bitn <= '0;
                if (bidx != 2'd3 && samp) begin
                  nack_q <= 1'b1;
                  ph     <= PH_STOP;
                end else begin
                  case (bidx)
                    2'd0: begin
                      bidx  <= 2'd1;
                      shreg <= c_q;
                    end
                    2'd1: begin
                      bidx <= 2'd2;
                      if (rd_q) begin
                        ph      <= PH_START;
                        first_q <= 1'b0;
                      end else begin
                        shreg <= d_q;
                      end
                    end
                    2'd2: begin
                      if (rd_q) begin
                        bidx  <= 2'd3;
                        shreg <= '1;
                      end else begin
                        ph <= PH_STOP;
                      end
                    end
                    default: begin
                      rx_byte <= shreg;
                      ph      <= PH_STOP;
                    end
                  endcase
                end
              end
            end
          end
        end
        default: begin
          if (tick) begin
            if (q == 2'd3) begin
              ph        <= PH_IDLE;
              q         <= '0;
              done      <= 1'b1;
              done_rd   <= rd_q;
              done_nack <= nack_q;
            end else begin
              q <= q + 2'd1;
            end
          end
        end
      endcase
    end
  end

  always_comb begin
    scl_low = 1'b0;
    sda_low = 1'b0;
    case (ph)
      PH_START: begin
        scl_low = (q == 2'd0) ? !first_q : (q == 2'd3);
        sda_low = (q >= 2'd2);
      end
      PH_BYTE: begin
        scl_low = (q == 2'd0) || (q == 2'd3);
        sda_low = (bitn != ACK_SLOT) && (bidx != 2'd3) && !shreg[DW-1];
      end
      PH_STOP: begin
        scl_low = (q == 2'd0);
        sda_low = (q <= 2'd1);
      end
      default: begin
        scl_low = 1'b0;
        sda_low = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_oe <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      scl_oe <= scl_low;
      sda_oe <= sda_low;
    end
  end
endmodule

// File: rtl/smb_irq_ctrl.sv
module smb_irq_ctrl
  import smb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            client_lvl,
  input  logic            done,
  input  logic            done_rd,
  input  logic            done_nack,
  input  logic            clr_en,
  input  logic [ST_W-1:0] clr_bits,
  input  logic            mask_we,
  input  logic [ST_W-1:0] mask_wdata,
  output logic [ST_W-1:0] status,
  output logic [ST_W-1:0] mask,
  output logic            irq_out
);
  logic            client_prev;
  logic [ST_W-1:0] set_bits;
  logic [ST_W-1:0] clr_vec;

  always_comb begin
    set_bits            = '0;
    set_bits[ST_CLIENT] = client_lvl && !client_prev;
    set_bits[ST_WDONE]  = done && !done_rd;
    set_bits[ST_RDONE]  = done && done_rd;
    set_bits[ST_NACK]   = done && done_nack;
    clr_vec             = clr_en ? clr_bits : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      client_prev <= 1'b0;
      status      <= '0;
      mask        <= MASK_RST;
      irq_out     <= 1'b0;
    end else begin
      client_prev <= client_lvl;
      status      <= (status & ~clr_vec) | set_bits;
      if (mask_we) mask <= mask_wdata;
      irq_out     <= |(status & ~mask);
    end
  end
endmodule

// File: rtl/smbus_bytemaster.sv
module smbus_bytemaster
  import smb_pkg::*;
#(
  parameter int unsigned QUARTER_DIV = 62,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              sda_in,
  input  logic              client_irq_in,
  output logic              irq_out
);
  logic [6:0]      taddr_q;
  logic [7:0]      cmd_q, wdat_q, rx_q;
  logic [ST_W-1:0] st_q, mask_q;
  logic            tick, sda_s, client_s;
  logic            eng_busy, eng_done, eng_done_rd, eng_done_nack;
  logic            start_req;

  assign start_req = bus_wr && (bus_addr == OFS_CTRL) && !eng_busy && (|bus_wdata[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      taddr_q <= '0;
      cmd_q   <= '0;
      wdat_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        OFS_TADDR: taddr_q <= bus_wdata[6:0];
        OFS_CMD:   cmd_q   <= bus_wdata;
        OFS_WDATA: wdat_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_CTRL:  bus_rdata <= {eng_busy, 7'd0};
        OFS_TADDR: bus_rdata <= {1'b0, taddr_q};
        OFS_CMD:   bus_rdata <= cmd_q;
        OFS_WDATA: bus_rdata <= wdat_q;
        OFS_RDATA: bus_rdata <= rx_q;
        OFS_STAT:  bus_rdata <= {{(8-ST_W){1'b0}}, st_q};
        OFS_MASK:  bus_rdata <= {{(8-ST_W){1'b0}}, mask_q};
        default:   bus_rdata <= '0;
      endcase
    end
  end

  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_s)
  );

  smb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_cli_sync (
    .clk(clk), .rst(rst), .d(client_irq_in), .q(client_s)
  );

  smb_quarter_tick #(.QDIV(QUARTER_DIV)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  smb_bit_engine #(.AW(7), .DW(8)) u_eng (
    .clk(clk), .rst(rst), .tick(tick),
    .start(start_req), .start_rd(!bus_wdata[0]),
    .tgt_addr(taddr_q), .cmd(cmd_q), .wdata(wdat_q),
    .sda_s(sda_s), .busy(eng_busy),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(eng_done), .done_rd(eng_done_rd), .done_nack(eng_done_nack),
    .rx_byte(rx_q)
  );

  smb_irq_ctrl u_irq (
    .clk(clk), .rst(rst), .client_lvl(client_s),
    .done(eng_done), .done_rd(eng_done_rd), .done_nack(eng_done_nack),
    .clr_en(bus_wr && (bus_addr == OFS_STAT)), .clr_bits(bus_wdata[ST_W-1:0]),
    .mask_we(bus_wr && (bus_addr == OFS_MASK)), .mask_wdata(bus_wdata[ST_W-1:0]),
    .status(st_q), .mask(mask_q), .irq_out(irq_out)
  );
endmodule

// File: rtl/smbus_bytemaster_sva.sv
module smbus_bytemaster_sva
  import smb_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              bus_wr,
  input logic [REG_AW-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              done,
  input logic              done_rd,
  input logic              done_nack,
  input logic [ST_W-1:0]   status,
  input logic [ST_W-1:0]   mask,
  input logic              irq_out,
  input logic [7:0]        rx_byte
);
  assert_lines_free_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!scl_oe && !sda_oe));

  assert_start_from_ctrl_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(bus_wr && bus_addr == OFS_CTRL));

  assert_wr_done_R5: assert property (@(posedge clk) disable iff (rst)
    (done && !done_rd) |=> status[ST_WDONE]);

  assert_rd_done_R5: assert property (@(posedge clk) disable iff (rst)
    (done && done_rd) |=> status[ST_RDONE]);

  assert_nack_flag_R6: assert property (@(posedge clk) disable iff (rst)
    (done && done_nack) |=> status[ST_NACK]);

  assert_w1c_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_STAT && bus_wdata[ST_WDONE] && !done) |=> !status[ST_WDONE]);

  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (status[ST_NACK] && !(bus_wr && bus_addr == OFS_STAT && bus_wdata[ST_NACK])) |=> status[ST_NACK]);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_out) |-> $past(|(status & ~mask)));

  assert_rx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(rx_byte));
endmodule

bind smbus_bytemaster smbus_bytemaster_sva u_sva (
  .clk(clk), .rst(rst), .busy(eng_busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .done(eng_done), .done_rd(eng_done_rd), .done_nack(eng_done_nack),
  .status(st_q), .mask(mask_q), .irq_out(irq_out), .rx_byte(rx_q)
);

// File: tb/smbus_bytemaster_test.sv
module smbus_bytemaster_test;
  localparam logic [6:0] TGT = 7'h2B;
  localparam int NROWS = 9;
  // {rd, addr[6:0], cmd, data, nack_at[3:0], exp_status[3:0], exp_byte}
  localparam logic [39:0] VEC [NROWS] = '{
    {1'b0, 7'h2B, 8'h10, 8'hA5, 4'hF, 4'h2, 8'hA5},
    {1'b1, 7'h2B, 8'h10, 8'h00, 4'hF, 4'h4, 8'hA5},
    {1'b1, 7'h2B, 8'h33, 8'h00, 4'hF, 4'h4, 8'h69},
    {1'b0, 7'h11, 8'h20, 8'h77, 4'hF, 4'hA, 8'h7A},
    {1'b0, 7'h2B, 8'h21, 8'h3C, 4'h2, 4'hA, 8'h7B},
    {1'b1, 7'h2B, 8'h40, 8'h00, 4'h1, 4'hC, 8'h69},
    {1'b1, 7'h2B, 8'h22, 8'h00, 4'h2, 4'hC, 8'h69},
    {1'b0, 7'h2B, 8'h7E, 8'h00, 4'hF, 4'h2, 8'h00},
    {1'b1, 7'h2B, 8'hFF, 8'h00, 4'hF, 4'h4, 8'hA5}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic scl_oe, sda_oe, irq_out;
  logic client = 1'b0;
  logic tgt_low = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | tgt_low);

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  smbus_bytemaster #(.QUARTER_DIV(4), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .scl_oe(scl_oe),
    .sda_oe(sda_oe), .sda_in(sda_line), .client_irq_in(client), .irq_out(irq_out)
  );

  // target model
  logic [7:0] mem [256];
  logic [7:0] shr, ptr, txb;
  logic rw = 1'b0, active = 1'b0, txmode = 1'b0, ackd = 1'b0;
  int bcnt = 0, byte_no = 0, total = 0, nack_at = 15, wr_count = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    active = 1'b1; txmode = 1'b0; bcnt = 0; byte_no = 0; tgt_low = 1'b0;
  end

  always @(posedge sda_line) if (scl_line === 1'b1) begin
    active = 1'b0; txmode = 1'b0; tgt_low = 1'b0; total = 0;
  end

  always @(posedge scl_line) if (active && !txmode && bcnt < 8) begin
    shr = {shr[6:0], sda_line};
    bcnt++;
  end

  always @(negedge scl_line) if (active) begin
    if (!txmode) begin
      if (bcnt == 8) begin
        ackd = 1'b1;
        if (total == nack_at) ackd = 1'b0;
        if (byte_no == 0 && shr[7:1] != TGT) ackd = 1'b0;
        if (byte_no == 0) rw = shr[0];
        else if (byte_no == 1) ptr = shr;
        else if (ackd && !rw) begin mem[ptr] = shr; wr_count++; end
        total++;
        tgt_low = ackd;
        bcnt = 9;
      end else if (bcnt == 9) begin
        tgt_low = 1'b0;
        bcnt = 0;
        if (!ackd) active = 1'b0;
        else if (byte_no == 0 && rw) begin
          txmode = 1'b1; txb = mem[ptr]; tgt_low = ~txb[7]; bcnt = 1;
        end
        byte_no++;
      end
    end else begin
      if (bcnt < 8) begin tgt_low = ~txb[7-bcnt]; bcnt++; end
      else if (bcnt == 8) begin tgt_low = 1'b0; bcnt = 9; end
      else active = 1'b0;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int k = 0; k < 20000; k++) begin
      rd(3'd0, v);
      if (!v[7]) break;
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hang expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [39:0] row;
    int wc0;
    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(3'd5, v); chk("R1 status", v, 8'h00);
    rd(3'd6, v); chk("R1 mask", v, 8'h01);
    rd(3'd0, v); chk("R1 ctrl", v, 8'h00);
    chk("R1 irq", irq_out, 1'b0);
    chk("R1 lines", {scl_oe, sda_oe}, 2'b00);

    // vector table
    for (int r = 0; r < NROWS; r++) begin
      row = VEC[r];
      nack_at = int'(row[15:12]);
      wr(3'd1, {1'b0, row[38:32]});
      wr(3'd2, row[31:24]);
      wr(3'd3, row[23:16]);
      wr(3'd0, row[39] ? 8'h02 : 8'h01);
      wait_idle();
      repeat (3) @(negedge clk);
      rd(3'd5, v);
      chk(row[11] ? "R6 status" : "R5 status", v, {4'h0, row[11:8]});
      chk("R9 irq adapter", irq_out, 1'b1);
      chk("R1 lines idle", {scl_oe, sda_oe}, 2'b00);
      if (row[39]) begin
        rd(3'd4, v);
        chk(row[11] ? "R10 rdata kept" : "R3 rdata", v, row[7:0]);
      end else begin
        chk(row[11] ? "R6 no write" : "R2 target byte", mem[row[31:24]], row[7:0]);
      end
      wr(3'd5, 8'h0F);
      rd(3'd5, v); chk("R7 clear all", v, 8'h00);
    end
    nack_at = 15;

    // R4: control write while busy is ignored
    wc0 = wr_count;
    wr(3'd1, {1'b0, TGT});
    wr(3'd2, 8'h50);
    wr(3'd3, 8'h11);
    wr(3'd0, 8'h01);
    wr(3'd2, 8'h51);
    wr(3'd0, 8'h01);
    rd(3'd0, v); chk("R4 busy bit", v[7], 1'b1);
    wait_idle();
    repeat (3) @(negedge clk);
    chk("R4 single transfer", wr_count - wc0, 1);
    chk("R4 captured cmd", mem[8'h50], 8'h11);
    chk("R4 later cmd unused", mem[8'h51], 8'h0B);
    rd(3'd5, v); chk("R4 status", v, 8'h02);
    rd(3'd4, v); chk("R10 rdata after write", v, 8'hA5);

    // R7 partial clear
    wr(3'd5, 8'h0F);
    wr(3'd1, 8'h11);
    wr(3'd0, 8'h01);
    wait_idle();
    repeat (3) @(negedge clk);
    wr(3'd5, 8'h02);
    rd(3'd5, v); chk("R7 zero keeps", v, 8'h08);
    wr(3'd5, 8'h08);
    rd(3'd5, v); chk("R7 one clears", v, 8'h00);
    wr(3'd1, {1'b0, TGT});

    // R9 / R11 client interrupt
    @(negedge clk); client = 1'b1;
    repeat (6) @(negedge clk);
    rd(3'd5, v); chk("R11 client edge", v, 8'h01);
    chk("R9 masked irq", irq_out, 1'b0);
    wr(3'd6, 8'h00);
    @(negedge clk);
    chk("R9 unmasked irq", irq_out, 1'b1);
    wr(3'd5, 8'h01);
    repeat (6) @(negedge clk);
    rd(3'd5, v); chk("R11 level no retrigger", v, 8'h00);
    chk("R9 irq cleared", irq_out, 1'b0);

    // R8 set and clear on the same edge
    client = 1'b0;
    repeat (6) @(negedge clk);
    @(negedge clk); client = 1'b1;
    @(negedge clk);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h01;
    @(negedge clk); bus_wr = 1'b0;
    rd(3'd5, v); chk("R8 event wins", v, 8'h01);
    wr(3'd5, 8'h01);
    rd(3'd5, v); chk("R8 later clear", v, 8'h00);

    finish_run();
  end
endmodule